// File: doc/BRIEF.md
# Multi-Master Bus Crossbar with Per-Target Arbitration

This block joins four bus masters to eight bus targets with a single-cycle, ready-qualified transfer protocol. Each master presents a request with an address, a write flag and write data. The top bits of the address pick a target through a fixed map. A per-master permission mask then decides whether that master may reach that target. A request that falls outside the map, or that the mask refuses, is answered at once with an error and never reaches a target.

Every target has its own arbiter, so masters heading to different targets complete in the same cycle without interfering. When several masters want the same target, its arbiter rotates among them by default. Software can also name one favoured master per target together with a run length N. The favoured master then gets up to N back-to-back completed transfers, the next waiting master in turn gets one, and the run begins again. This keeps traffic of one kind bunched together. A target that inserts wait states keeps the master it has chosen until the transfer ends. Arbitration settings are written through a small write port. New settings are held until the target is not in the middle of a stalled transfer.

Top module: `mlx_matrix`

## Requirements
- R1: Address bits [15:12] form a region number. Regions 0 to 7 select the target of the same index. Regions 8 to 15 are unmapped.
- R2: Masters whose requests go to different targets, all of which have `s_ready` high, all see `m_ready` high in the same cycle.
- R3: A target serves at most one master in any cycle. When `s_sel` is high, `s_mid` names a master that is requesting that target, and that master's address, write flag and write data appear on the target's side. The target's read data is returned to the master on `m_rdata`.
- R4: With no run length configured (N of 0 or 1), a target's arbiter rotates through the masters in index order. After master k completes, the search starts at k+1. After reset the search starts at master 0.
- R5: With N above 1 and favoured master P, P wins up to N consecutive completed transfers while it requests. After that, the next non-favoured requester in rotation order wins one transfer, and the run count restarts. If no other master is waiting, P keeps the grant.
- R6: A requesting master that is not granted sees `m_ready` low. While a granted transfer waits on `s_ready` low, the target's `s_mid` stays unchanged until the transfer completes.
- R7: A request that is unmapped or refused by the mask sees `m_ready` and `m_err` high in the same cycle, and no target is selected for that master.
- R8: A write with `perm_we` loads `perm_mask` for master `perm_master`. Bit s set allows target s. After reset every target is allowed. The new mask applies from the cycle after the write.
- R9: A write with `cfg_we` sets the favoured master `cfg_pref` and run length `cfg_burst` for target `cfg_slave`. The new settings take effect at the first clock edge at which that target is not holding a stalled transfer, and the run count restarts there. After reset N is 0 and the favoured master is 0.
- R10: Any master that keeps requesting a target that answers ready is eventually granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_req | input | 4 | Per-master request, held until `m_ready` |
| m_addr | input | 64 | Per-master address, 16 bits each |
| m_wr | input | 4 | Per-master write flag |
| m_wdata | input | 128 | Per-master write data, 32 bits each |
| m_ready | output | 4 | Transfer completes this cycle |
| m_err | output | 4 | Completion carries an error |
| m_rdata | output | 128 | Read data returned to each master |
| s_sel | output | 8 | Target selected this cycle |
| s_mid | output | 16 | Index of the master driving each target, 2 bits each |
| s_addr | output | 128 | Address forwarded to each target |
| s_wr | output | 8 | Write flag forwarded to each target |
| s_wdata | output | 256 | Write data forwarded to each target |
| s_ready | input | 8 | Target accepts the transfer this cycle |
| s_rdata | input | 256 | Read data from each target |
| perm_we | input | 1 | Permission mask write strobe |
| perm_master | input | 2 | Master whose mask is written |
| perm_mask | input | 8 | New allowed-target mask |
| cfg_we | input | 1 | Arbitration settings write strobe |
| cfg_slave | input | 3 | Target whose settings are written |
| cfg_pref | input | 2 | Favoured master |
| cfg_burst | input | 4 | Run length N |

## Verification
The embedded properties watch, on every cycle, that a selected target always names a master that is actually requesting it, that a stalled grant does not move, that new arbitration settings only land when the target is not mid-stall, and that an error completion never coexists with a grant for the same master. The grant order is a different matter: rotation from master 0 after reset, the N-then-one pattern of the favoured master, and the deferral of a setting written during a stall only show up over sequences of transfers. The bench shows these through directed scenarios and a behavioural model compared every cycle under random traffic, random wait states and random reconfiguration, while counting each master's waiting time.

// File: rtl/mlx_pkg.sv
package mlx_pkg;
  localparam int unsigned N_MST   = 4;
  localparam int unsigned N_SLV   = 8;
  localparam int unsigned ADDR_W  = 16;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned BURST_W = 4;
endpackage

// File: rtl/mlx_decode.sv
module mlx_decode #(
  parameter int unsigned AW = 16,
  parameter int unsigned NS = 8,
  localparam int unsigned RW = $clog2(NS) + 1
) (
  input  logic [AW-1:0] addr,
  input  logic [NS-1:0] allow,
  output logic [NS-1:0] hit,
  output logic          bad
);
  logic [RW-1:0] region;

  assign region = addr[AW-1 -: RW];

  for (genvar s = 0; s < NS; s++) begin : g_hit
    assign hit[s] = (region == RW'(s)) && allow[s];
  end

  assign bad = ~|hit;

  // unmapped regions never reach a target (R1)
  always_comb begin
    if (region >= RW'(NS)) begin
      a_unmapped_r1: assert (hit == '0);
    end
  end
endmodule

// File: rtl/mlx_arbiter.sv
module mlx_arbiter #(
  parameter int unsigned NM = 4,
  parameter int unsigned BW = 4,
  localparam int unsigned MIW = $clog2(NM)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NM-1:0]  req,
  input  logic           ready,
  input  logic           cfg_we,
  input  logic [MIW-1:0] cfg_pref,
  input  logic [BW-1:0]  cfg_burst,
  output logic           gnt_v,
  output logic [MIW-1:0] gnt_id
);
  logic [MIW-1:0] rr_q, rr_d, pref_q, pref_d, lid_q, pp_q, pp_d;
  logic [BW-1:0]  run_q, run_d, burst_q, burst_d, pb_q, pb_d;
  logic           lock_q, lock_d, pv_q, pv_d;
  logic           burst_en, oth_f, done;
  logic [MIW-1:0] oth_id;

  assign burst_en = burst_q > BW'(1);

  always_comb begin
    oth_f  = 1'b0;
    oth_id = '0;
    for (int k = 1; k <= NM; k++) begin
      int unsigned idx;
      idx = (int'(rr_q) + k) % NM;
      if (!oth_f && req[idx] && !(burst_en && (MIW'(idx) == pref_q))) begin
        oth_f  = 1'b1;
        oth_id = MIW'(idx);
      end
    end
  end

  always_comb begin
    if (lock_q) begin
      gnt_id = lid_q;
      gnt_v  = req[lid_q];
    end else if (burst_en && req[pref_q] && ((run_q < burst_q) || !oth_f)) begin
      gnt_id = pref_q;
      gnt_v  = 1'b1;
    end else begin
      gnt_id = oth_id;
      gnt_v  = oth_f;
    end
  end

  assign done   = gnt_v && ready;
  assign lock_d = gnt_v && !ready;

  always_comb begin
    rr_d    = rr_q;
    run_d   = run_q;
    burst_d = burst_q;
    pref_d  = pref_q;
    if (done) begin
      if (burst_en && (gnt_id == pref_q)) begin
        run_d = (run_q == '1) ? run_q : run_q + BW'(1);
      end else begin
        run_d = '0;
        rr_d  = gnt_id;
      end
    end
    pv_d = cfg_we ? 1'b1      : pv_q;
    pp_d = cfg_we ? cfg_pref  : pp_q;
    pb_d = cfg_we ? cfg_burst : pb_q;
    if (pv_d && !lock_d) begin
      burst_d = pb_d;
      pref_d  = pp_d;
      run_d   = '0;
      pv_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q    <= MIW'(NM - 1);
      run_q   <= '0;
      burst_q <= '0;
      pref_q  <= '0;
      lock_q  <= 1'b0;
      lid_q   <= '0;
      pv_q    <= 1'b0;
      pp_q    <= '0;
      pb_q    <= '0;
    end else begin
      rr_q    <= rr_d;
      run_q   <= run_d;
      burst_q <= burst_d;
      pref_q  <= pref_d;
      lock_q  <= lock_d;
      lid_q   <= gnt_id;
      pv_q    <= pv_d;
      pp_q    <= pp_d;
      pb_q    <= pb_d;
    end
  end

  p_hold_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_v && !ready) |=> (gnt_id == $past(gnt_id)));

  p_cfg_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((burst_q != $past(burst_q)) || (pref_q != $past(pref_q))) |-> !lock_q);
endmodule

// File: rtl/mlx_matrix.sv
module mlx_matrix
  import mlx_pkg::*;
#(
  parameter int unsigned NM = N_MST,
  parameter int unsigned NS = N_SLV,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned BW = BURST_W,
  localparam int unsigned MIW = $clog2(NM),
  localparam int unsigned SIW = $clog2(NS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NM-1:0]     m_req,
  input  logic [NM*AW-1:0]  m_addr,
  input  logic [NM-1:0]     m_wr,
  input  logic [NM*DW-1:0]  m_wdata,
  output logic [NM-1:0]     m_ready,
  output logic [NM-1:0]     m_err,
  output logic [NM*DW-1:0]  m_rdata,
  output logic [NS-1:0]     s_sel,
  output logic [NS*MIW-1:0] s_mid,
  output logic [NS*AW-1:0]  s_addr,
  output logic [NS-1:0]     s_wr,
  output logic [NS*DW-1:0]  s_wdata,
  input  logic [NS-1:0]     s_ready,
  input  logic [NS*DW-1:0]  s_rdata,
  input  logic              perm_we,
  input  logic [MIW-1:0]    perm_master,
  input  logic [NS-1:0]     perm_mask,
  input  logic              cfg_we,
  input  logic [SIW-1:0]    cfg_slave,
  input  logic [MIW-1:0]    cfg_pref,
  input  logic [BW-1:0]     cfg_burst
);
  logic [NS-1:0]  mask_q [NM];
  logic [NS-1:0]  mask_d [NM];
  logic [NS-1:0]  hit    [NM];
  logic [NM-1:0]  bad;
  logic [NM-1:0]  sreq   [NS];
  logic [NS-1:0]  gv;
  logic [MIW-1:0] gid    [NS];
  logic [NM-1:0]  owns;

  always_comb begin
    for (int m = 0; m < NM; m++) begin
      mask_d[m] = mask_q[m];
      if (perm_we && (perm_master == MIW'(m))) mask_d[m] = perm_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int m = 0; m < NM; m++) mask_q[m] <= '1;
    end else begin
      for (int m = 0; m < NM; m++) mask_q[m] <= mask_d[m];
    end
  end

  for (genvar m = 0; m < NM; m++) begin : g_mst
    mlx_decode #(.AW(AW), .NS(NS)) u_dec (
      .addr  (m_addr[m*AW +: AW]),
      .allow (mask_q[m]),
      .hit   (hit[m]),
      .bad   (bad[m])
    );
  end

  for (genvar s = 0; s < NS; s++) begin : g_slv
    always_comb begin
      for (int m = 0; m < NM; m++) sreq[s][m] = m_req[m] && hit[m][s];
    end

    mlx_arbiter #(.NM(NM), .BW(BW)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (sreq[s]),
      .ready     (s_ready[s]),
      .cfg_we    (cfg_we && (cfg_slave == SIW'(s))),
      .cfg_pref  (cfg_pref),
      .cfg_burst (cfg_burst),
      .gnt_v     (gv[s]),
      .gnt_id    (gid[s])
    );

    assign s_sel[s]                = gv[s];
    assign s_mid[s*MIW +: MIW]     = gid[s];
    assign s_addr[s*AW +: AW]      = m_addr[gid[s]*AW +: AW];
    assign s_wr[s]                 = m_wr[gid[s]];
    assign s_wdata[s*DW +: DW]     = m_wdata[gid[s]*DW +: DW];

    p_mid_requests_r3: assert property (@(posedge clk) disable iff (!rst_n)
      s_sel[s] |-> (m_req[s_mid[s*MIW +: MIW]] &&
                    (m_addr[s_mid[s*MIW +: MIW]*AW + AW - SIW - 1 +: SIW + 1] == (SIW+1)'(s))));
  end

  always_comb begin
    for (int m = 0; m < NM; m++) begin
      m_err[m]            = m_req[m] && bad[m];
      m_ready[m]          = m_err[m];
      m_rdata[m*DW +: DW] = '0;
      owns[m]             = 1'b0;
      for (int s = 0; s < NS; s++) begin
        if (hit[m][s]) m_rdata[m*DW +: DW] = s_rdata[s*DW +: DW];
        if (gv[s] && (gid[s] == MIW'(m))) begin
          owns[m] = 1'b1;
          if (s_ready[s]) m_ready[m] = 1'b1;
        end
      end
    end
  end

  for (genvar m = 0; m < NM; m++) begin : g_chk
    p_err_no_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
      m_err[m] |-> (m_ready[m] && !owns[m]));
  end
endmodule

// File: tb/mlx_matrix_tb.sv
module mlx_matrix_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 100;

  logic clk = 1'b0;
  logic rst_n;
  logic [3:0]   m_req;
  logic [63:0]  m_addr;
  logic [3:0]   m_wr;
  logic [127:0] m_wdata;
  logic [3:0]   m_ready, m_err;
  logic [127:0] m_rdata;
  logic [7:0]   s_sel, s_wr, s_ready;
  logic [15:0]  s_mid;
  logic [127:0] s_addr;
  logic [255:0] s_wdata, s_rdata;
  logic         perm_we, cfg_we;
  logic [1:0]   perm_master, cfg_pref;
  logic [7:0]   perm_mask;
  logic [2:0]   cfg_slave;
  logic [3:0]   cfg_burst;

  always #(CLK_PERIOD/2) clk = ~clk;

  mlx_matrix u_dut (
    .clk(clk), .rst_n(rst_n),
    .m_req(m_req), .m_addr(m_addr), .m_wr(m_wr), .m_wdata(m_wdata),
    .m_ready(m_ready), .m_err(m_err), .m_rdata(m_rdata),
    .s_sel(s_sel), .s_mid(s_mid), .s_addr(s_addr), .s_wr(s_wr), .s_wdata(s_wdata),
    .s_ready(s_ready), .s_rdata(s_rdata),
    .perm_we(perm_we), .perm_master(perm_master), .perm_mask(perm_mask),
    .cfg_we(cfg_we), .cfg_slave(cfg_slave), .cfg_pref(cfg_pref), .cfg_burst(cfg_burst)
  );

  int nchk = 0, nerr = 0;
  bit finished = 0;

  // reference state
  int rr[8], run[8], bur[8], prf[8], lk[8], lid[8], pv[8], pp[8], pb[8];
  int n_rr[8], n_run[8], n_bur[8], n_prf[8], n_lk[8], n_lid[8], n_pv[8], n_pp[8], n_pb[8];
  logic [7:0] mk[4], n_mk[4];
  int ev[8], eid[8], etgt[4], wcnt[4];
  bit erdy[4], eerr[4];
  logic [3:0] smp_rdy, smp_err;
  logic [7:0] smp_sel;
  int smp_mid[8];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < 8; s++) begin
      rr[s] = 3; run[s] = 0; bur[s] = 0; prf[s] = 0; lk[s] = 0; lid[s] = 0;
      pv[s] = 0; pp[s] = 0; pb[s] = 0;
    end
    for (int m = 0; m < 4; m++) begin mk[m] = 8'hFF; wcnt[m] = 0; end
  endtask

  task automatic model_eval();
    for (int m = 0; m < 4; m++) begin
      etgt[m] = -1; eerr[m] = 0;
      if (m_req[m]) begin
        int r;
        r = int'(m_addr[m*16+12 +: 4]);
        if (r < 8 && mk[m][r]) etgt[m] = r; else eerr[m] = 1;
      end
    end
    for (int s = 0; s < 8; s++) begin
      bit rq[4];
      for (int m = 0; m < 4; m++) rq[m] = (etgt[m] == s);
      if (lk[s] != 0) begin
        eid[s] = lid[s]; ev[s] = rq[lid[s]] ? 1 : 0;
      end else begin
        bit en;
        int oid;
        en = bur[s] > 1; oid = -1;
        for (int k = 1; k <= 4; k++) begin
          int c;
          c = (rr[s] + k) % 4;
          if (oid < 0 && rq[c] && !(en && c == prf[s])) oid = c;
        end
        if (en && rq[prf[s]] && (run[s] < bur[s] || oid < 0)) begin
          ev[s] = 1; eid[s] = prf[s];
        end else begin
          ev[s] = (oid >= 0) ? 1 : 0; eid[s] = (oid < 0) ? 0 : oid;
        end
      end
    end
    for (int m = 0; m < 4; m++)
      erdy[m] = eerr[m] || (etgt[m] >= 0 && ev[etgt[m]] != 0 && eid[etgt[m]] == m && s_ready[etgt[m]]);
    // next state
    for (int s = 0; s < 8; s++) begin
      int cpv, cpp, cpb;
      n_rr[s] = rr[s]; n_run[s] = run[s]; n_bur[s] = bur[s]; n_prf[s] = prf[s];
      n_lk[s] = (ev[s] != 0 && !s_ready[s]) ? 1 : 0; n_lid[s] = eid[s];
      if (ev[s] != 0 && s_ready[s]) begin
        if (bur[s] > 1 && eid[s] == prf[s]) n_run[s] = (run[s] < 15) ? run[s] + 1 : 15;
        else begin n_run[s] = 0; n_rr[s] = eid[s]; end
      end
      if (cfg_we && int'(cfg_slave) == s) begin
        cpv = 1; cpp = int'(cfg_pref); cpb = int'(cfg_burst);
      end else begin
        cpv = pv[s]; cpp = pp[s]; cpb = pb[s];
      end
      n_pv[s] = cpv; n_pp[s] = cpp; n_pb[s] = cpb;
      if (cpv != 0 && n_lk[s] == 0) begin
        n_bur[s] = cpb; n_prf[s] = cpp; n_run[s] = 0; n_pv[s] = 0;
      end
    end
    for (int m = 0; m < 4; m++) n_mk[m] = mk[m];
    if (perm_we) n_mk[perm_master] = perm_mask;
  endtask

  task automatic compare();
    for (int s = 0; s < 8; s++) begin
      chk(s_sel[s] == (ev[s] != 0), "R3 target select", s_sel[s], ev[s]);
      if (ev[s] != 0) begin
        chk(int'(s_mid[s*2 +: 2]) == eid[s], "R4/R5 granted master", s_mid[s*2 +: 2], eid[s]);
        chk(s_addr[s*16 +: 16] == m_addr[eid[s]*16 +: 16], "R3 forwarded address",
            s_addr[s*16 +: 16], m_addr[eid[s]*16 +: 16]);
        chk(s_wdata[s*32 +: 32] == m_wdata[eid[s]*32 +: 32] && s_wr[s] == m_wr[eid[s]],
            "R3 forwarded write", s_wdata[s*32 +: 32], m_wdata[eid[s]*32 +: 32]);
      end
    end
    for (int m = 0; m < 4; m++) begin
      int cnt;
      chk(m_ready[m] == erdy[m], "R6 master ready", m_ready[m], erdy[m]);
      chk(m_err[m] == eerr[m], "R7 master error", m_err[m], eerr[m]);
      if (erdy[m] && !eerr[m])
        chk(m_rdata[m*32 +: 32] == s_rdata[etgt[m]*32 +: 32], "R3 read data",
            m_rdata[m*32 +: 32], s_rdata[etgt[m]*32 +: 32]);
      cnt = 0;
      for (int k = 0; k < 4; k++) if (m_ready[k] && !m_err[k] && etgt[k] == m) cnt++;
      chk(cnt <= 1, "R3 one master per target", cnt, 1);
      if (m_req[m] && !m_ready[m]) wcnt[m]++;
      else begin
        if (m_req[m]) chk(wcnt[m] <= LIMIT, "R10 bounded wait", wcnt[m], LIMIT);
        wcnt[m] = 0;
      end
    end
  endtask

  task automatic step();
    #1;
    model_eval();
    compare();
    smp_rdy = m_ready; smp_err = m_err; smp_sel = s_sel;
    for (int s = 0; s < 8; s++) smp_mid[s] = int'(s_mid[s*2 +: 2]);
    @(posedge clk);
    for (int s = 0; s < 8; s++) begin
      rr[s] = n_rr[s]; run[s] = n_run[s]; bur[s] = n_bur[s]; prf[s] = n_prf[s];
      lk[s] = n_lk[s]; lid[s] = n_lid[s]; pv[s] = n_pv[s]; pp[s] = n_pp[s]; pb[s] = n_pb[s];
    end
    for (int m = 0; m < 4; m++) mk[m] = n_mk[m];
    @(negedge clk);
    cfg_we = 0; perm_we = 0;
  endtask

  task automatic set_m(input int m, input bit rq, input logic [15:0] a);
    m_req[m] = rq;
    m_addr[m*16 +: 16] = a;
    m_wr[m] = a[0];
    m_wdata[m*32 +: 32] = {8'hA0, 6'(0), 2'(m), a};
  endtask

  task automatic write_cfg(input int s, input int p, input int n);
    cfg_we = 1; cfg_slave = 3'(s); cfg_pref = 2'(p); cfg_burst = 4'(n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog run did not finish");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int seq[16];
    rst_n = 0; m_req = '0; m_addr = '0; m_wr = '0; m_wdata = '0;
    s_ready = '1; perm_we = 0; perm_master = '0; perm_mask = '0;
    cfg_we = 0; cfg_slave = '0; cfg_pref = '0; cfg_burst = '0;
    for (int s = 0; s < 8; s++) s_rdata[s*32 +: 32] = 32'h5100_0000 + 32'(s * 17);
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    step();
    chk(smp_sel == 8'h00 && smp_rdy == 4'h0, "R6 reset outputs idle", {smp_sel, smp_rdy}, 0);

    // R2 parallel service
    set_m(0, 1, 16'h0010); set_m(1, 1, 16'h2020); set_m(2, 1, 16'h4031); set_m(3, 1, 16'h6040);
    step();
    chk(smp_rdy == 4'hF, "R2 all masters served together", smp_rdy, 4'hF);
    m_req = '0;
    step();

    // R4 rotation on untouched target 3
    for (int m = 0; m < 4; m++) set_m(m, 1, 16'h3000 + 16'(m));
    for (int i = 0; i < 8; i++) begin
      step();
      chk(smp_mid[3] == i % 4, "R4 rotation order from reset", smp_mid[3], i % 4);
    end

    // R5 favoured master run of 3
    write_cfg(3, 2, 3);
    step();
    for (int i = 0; i < 16; i++) begin
      step();
      chk((smp_mid[3] == 2) == (i % 4 != 3), "R5 favoured run then one other", smp_mid[3], i % 4);
    end

    // R6/R9 stall holds grant, config deferred
    s_ready[3] = 0;
    write_cfg(3, 0, 0);
    step();
    seq[0] = smp_mid[3];
    for (int i = 0; i < 2; i++) begin
      step();
      chk(smp_mid[3] == seq[0], "R6 grant stable during stall", smp_mid[3], seq[0]);
    end
    s_ready[3] = 1;
    step();
    chk(smp_mid[3] == seq[0] && smp_rdy[seq[0]], "R6 stalled transfer completes", smp_mid[3], seq[0]);
    for (int i = 0; i < 4; i++) begin step(); seq[i+1] = smp_mid[3]; end
    for (int i = 1; i < 4; i++)
      chk(seq[i+1] == (seq[i] + 1) % 4, "R9 plain rotation after deferred write", seq[i+1], (seq[i] + 1) % 4);
    m_req = '0;
    step();

    // R7/R8 mask refusal and R1 map
    perm_we = 1; perm_master = 2'd1; perm_mask = 8'hDF;
    step();
    set_m(1, 1, 16'h5000);
    step();
    chk(smp_err[1] && smp_rdy[1] && !smp_sel[5], "R8 masked target refused", {smp_err[1], smp_sel[5]}, 2'b10);
    set_m(1, 0, 16'h0); set_m(0, 1, 16'hF123);
    step();
    chk(smp_err[0] && smp_rdy[0] && smp_sel == 0, "R1 unmapped region errors", {smp_err[0], smp_sel}, 9'h100);
    set_m(0, 1, 16'h7000);
    step();
    chk(!smp_err[0] && smp_sel[7], "R1 region 7 reaches target 7", {smp_err[0], smp_sel[7]}, 2'b01);
    m_req = '0; perm_we = 1; perm_master = 2'd1; perm_mask = 8'hFF;
    step();

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      for (int m = 0; m < 4; m++) begin
        if (!m_req[m] || smp_rdy[m]) begin
          int r;
          r = int'($urandom % 6);
          set_m(m, ($urandom % 10) < 7, {(r == 5) ? 4'hF : 4'(r % 4), 12'($urandom)});
        end
      end
      for (int s = 0; s < 8; s++) s_ready[s] = ($urandom % 4) != 0;
      if ($urandom % 40 == 0) write_cfg(int'($urandom % 4), int'($urandom % 4), int'($urandom % 5));
      if ($urandom % 300 == 0) begin
        perm_we = 1; perm_master = 2'($urandom); perm_mask = 8'($urandom) | 8'h05;
      end
      step();
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule